// File: doc/BRIEF.md
# Serial Transmit Byte Sequencer with Starvation Guard

This block sits between a host that supplies message bytes and the bit-level encoder of a serial vehicle-network transmitter. The host writes a byte together with an opcode strobe. The opcode carries two flags. The first asks for the check byte to be appended after this byte. The second marks the frame as a message or a type-3 in-frame response, where more data must follow. The sequencer shifts each byte out most significant bit first, one bit per bit tick. It keeps a CRC-8 running over every data bit it sends.

When the current byte has no append request, the host must supply the next byte before the last bit of the current byte has been shifted. If it does, the new byte follows back-to-back. If it does not, and the frame is of the kind that expects more data, the sequencer does not stall. It sends the CRC register without the final inversion, which is a deliberately wrong check byte, and pulses an underflow flag toward the error logic. Frames of the other kind simply end after the byte.

Top module: `bts_txseq`

## Requirements
- R1: Each bit appears on `ser_bit` with a one-cycle `ser_stb` pulse in the clock cycle after a cycle with `bit_tick` high while busy. Bytes go out most significant bit first.
- R2: An `op_wr` while idle starts a message. It loads `data_in` as the first byte and seeds the CRC register with 0xFF. The first bit goes out on the first `bit_tick` after the write cycle.
- R3: The CRC register steps on every transmitted data bit with polynomial x^8+x^4+x^3+x^2+1 (0x1D, feedback = register bit 7 XOR data bit). Check-byte bits do not step it.
- R4: After a data byte whose opcode had `op_append_crc` = 1, the next byte is the ones-complement of the CRC register, with `crc_byte` high on each of its eight strobes.
- R5: An `op_wr` while a data byte without append is being shifted queues the next byte and its flags. This includes a write in the same cycle as that byte's final bit tick. The queued byte follows with no gap, and the CRC continues across it.
- R6: If no byte is queued by the final bit tick and the current opcode had `op_stream` = 1, the next byte is the uninverted CRC register with `crc_byte` high. `underflow` pulses together with the strobe of the last data bit.
- R7: If no byte is queued by the final bit tick and `op_stream` = 0, the message ends after the data byte with no check byte and no underflow.
- R8: `op_wr` is ignored while a check byte or a byte with append is being shifted. The output stream is unchanged.
- R9: A second `op_wr` during the same data byte replaces the byte queued by the first.
- R10: `byte_first` is high together with the strobe of bit 7 of every byte, and low otherwise.
- R11: While `rst` is high, all outputs are low.
- R12: `eod` pulses with the strobe of the last bit of a message. From that cycle on, `busy` is low until the next starting write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle bit-time enable from the shift timing |
| op_wr | input | 1 | Opcode write strobe; takes `data_in` and the flags |
| op_append_crc | input | 1 | Append the check byte after this byte |
| op_stream | input | 1 | Frame expects more data (message or type-3 response) |
| data_in | input | 8 | Byte to transmit |
| ser_bit | output | 1 | Serial bit, valid with `ser_stb` |
| ser_stb | output | 1 | Bit strobe |
| byte_first | output | 1 | Current strobe carries bit 7 of a byte |
| crc_byte | output | 1 | Current strobe belongs to a check byte |
| underflow | output | 1 | Data starvation pulse |
| eod | output | 1 | End-of-data pulse on the final bit |
| busy | output | 1 | A message is being shifted |

## Verification
The host write and the final bit tick of the current byte can fall in the same clock cycle. In that cycle the sequencer must decide between continuing with data and emitting the corrupted check byte. The bench places a write exactly on that final tick and expects seamless continuation with no underflow. It then places one write a single tick later, into the first bit of the check byte, and expects an underflow, a corrupted check byte, and the late byte discarded. A bit-level expectation queue built from a separate CRC model judges both outcomes on every strobe.

// File: rtl/bts_pkg.sv
package bts_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam logic [BYTE_W-1:0] CRC_POLY = 8'h1D;
    localparam logic [BYTE_W-1:0] CRC_SEED = 8'hFF;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {ST_IDLE, ST_SEND} seq_st_e;
    typedef enum logic {KIND_DATA, KIND_CHECK} kind_e;
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_DATA,
        ACT_CRC_OK,
        ACT_CRC_BAD,
        ACT_END
    } act_e;

    typedef struct packed {
        logic append;
        logic stream;
    } opflags_t;

    typedef struct packed {
        byte_t    data;
        opflags_t flags;
    } opword_t;

    function automatic byte_t crc_step(byte_t cur, logic din, byte_t poly);
        logic fb;
        fb = cur[BYTE_W-1] ^ din;
        return {cur[BYTE_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/bts_shift.sv
module bts_shift
    import bts_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  byte_t load_val,
    input  logic  shift,
    output logic  msb,
    output logic  first,
    output logic  last
);
    byte_t            sh_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            idx_q <= '0;
        end else if (shift) begin
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign msb   = sh_q[BYTE_W-1];
    assign first = (idx_q == '0);
    assign last  = (idx_q == IDX_W'(BYTE_W - 1));
endmodule

// File: rtl/bts_crc.sv
module bts_crc
    import bts_pkg::*;
#(
    parameter byte_t POLY = CRC_POLY,
    parameter byte_t SEED = CRC_SEED
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  init,
    input  logic  step,
    input  logic  bit_in,
    output byte_t crc_nxt
);
    byte_t crc_q;

    assign crc_nxt = crc_step(crc_q, bit_in, POLY);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= SEED;
        end else if (init) begin
            crc_q <= SEED;
        end else if (step) begin
            crc_q <= crc_nxt;
        end
    end
endmodule

// File: rtl/bts_hold.sv
module bts_hold
    import bts_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr,
    input  opword_t wr_word,
    input  logic    take,
    output logic    valid,
    output opword_t word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            word  <= '0;
        end else begin
            if (take) begin
                valid <= 1'b0;
            end else if (wr) begin
                valid <= 1'b1;
            end
            if (wr && !take) begin
                word <= wr_word;
            end
        end
    end
endmodule

// File: rtl/bts_txseq.sv
module bts_txseq
    import bts_pkg::*;
#(
    parameter byte_t POLY = CRC_POLY,
    parameter byte_t SEED = CRC_SEED
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       op_wr,
    input  logic       op_append_crc,
    input  logic       op_stream,
    input  logic [7:0] data_in,
    output logic       ser_bit,
    output logic       ser_stb,
    output logic       byte_first,
    output logic       crc_byte,
    output logic       underflow,
    output logic       eod,
    output logic       busy
);
    seq_st_e  st_q;
    kind_e    kind_q;
    opflags_t flags_q;
    act_e     act;

    logic    sh_msb, sh_first, sh_last, sh_load, sh_shift;
    byte_t   load_val, crc_nxt;
    logic    start, fin, accept_wr, wr_now, hold_valid, nxt_avail;
    opword_t in_word, hold_word, nxt_word;

    assign in_word   = '{data: data_in, flags: '{append: op_append_crc, stream: op_stream}};
    assign start     = (st_q == ST_IDLE) && op_wr;
    assign sh_shift  = (st_q == ST_SEND) && bit_tick;
    assign fin       = sh_shift && sh_last;
    assign accept_wr = (st_q == ST_SEND) && (kind_q == KIND_DATA) && !flags_q.append;
    assign wr_now    = op_wr && accept_wr;
    assign nxt_avail = wr_now || hold_valid;
    assign nxt_word  = wr_now ? in_word : hold_word;

    always_comb begin
        act = ACT_NONE;
        if (fin) begin
            if (kind_q == KIND_CHECK)  act = ACT_END;
            else if (flags_q.append)   act = ACT_CRC_OK;
            else if (nxt_avail)        act = ACT_DATA;
            else if (flags_q.stream)   act = ACT_CRC_BAD;
            else                       act = ACT_END;
        end
    end

    always_comb begin
        sh_load  = start;
        load_val = data_in;
        unique case (act)
            ACT_DATA:    begin sh_load = 1'b1; load_val = nxt_word.data; end
            ACT_CRC_OK:  begin sh_load = 1'b1; load_val = ~crc_nxt;      end
            ACT_CRC_BAD: begin sh_load = 1'b1; load_val = crc_nxt;       end
            default:     ;
        endcase
    end

    bts_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_val (load_val),
        .shift    (sh_shift),
        .msb      (sh_msb),
        .first    (sh_first),
        .last     (sh_last)
    );

    bts_crc #(.POLY(POLY), .SEED(SEED)) u_crc (
        .clk     (clk),
        .rst     (rst),
        .init    (start),
        .step    (sh_shift && (kind_q == KIND_DATA)),
        .bit_in  (sh_msb),
        .crc_nxt (crc_nxt)
    );

    bts_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_now),
        .wr_word (in_word),
        .take    (act == ACT_DATA),
        .valid   (hold_valid),
        .word    (hold_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            kind_q  <= KIND_DATA;
            flags_q <= '0;
        end else if (start) begin
            st_q    <= ST_SEND;
            kind_q  <= KIND_DATA;
            flags_q <= in_word.flags;
        end else begin
            unique case (act)
                ACT_DATA: begin
                    kind_q  <= KIND_DATA;
                    flags_q <= nxt_word.flags;
                end
                ACT_CRC_OK, ACT_CRC_BAD: kind_q <= KIND_CHECK;
                ACT_END: begin
                    st_q   <= ST_IDLE;
                    kind_q <= KIND_DATA;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_bit    <= 1'b0;
            ser_stb    <= 1'b0;
            byte_first <= 1'b0;
            crc_byte   <= 1'b0;
            underflow  <= 1'b0;
            eod        <= 1'b0;
        end else begin
            ser_bit    <= sh_shift && sh_msb;
            ser_stb    <= sh_shift;
            byte_first <= sh_shift && sh_first;
            crc_byte   <= sh_shift && (kind_q == KIND_CHECK);
            underflow  <= (act == ACT_CRC_BAD);
            eod        <= (act == ACT_END);
        end
    end

    assign busy = (st_q == ST_SEND);
endmodule

// File: rtl/bts_txseq_chk.sv
module bts_txseq_chk (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic ser_stb,
    input logic byte_first,
    input logic crc_byte,
    input logic underflow,
    input logic eod,
    input logic busy
);
    // R1
    stb_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ser_stb |-> $past(bit_tick));

    // R4
    crc_with_stb_chk: assert property (@(posedge clk) disable iff (rst)
        crc_byte |-> ser_stb);

    // R6
    uf_on_data_bit_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (ser_stb && !crc_byte));

    // R6
    uf_then_check_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |-> busy);

    // R10
    first_with_stb_chk: assert property (@(posedge clk) disable iff (rst)
        byte_first |-> ser_stb);

    // R12
    eod_idle_chk: assert property (@(posedge clk) disable iff (rst)
        eod |-> (ser_stb && !busy));

    // R12
    eod_uf_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(eod && underflow));
endmodule

bind bts_txseq bts_txseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .ser_stb    (ser_stb),
    .byte_first (byte_first),
    .crc_byte   (crc_byte),
    .underflow  (underflow),
    .eod        (eod),
    .busy       (busy)
);

// File: tb/bts_txseq_test.sv
module bts_txseq_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;
    logic bit_tick;
    assign bit_tick = (cyc[1:0] == 2'd0);

    int tk_total = 0;
    always @(posedge clk) if (bit_tick) tk_total <= tk_total + 1;
    logic tick_d = 1'b0;
    always @(posedge clk) tick_d <= bit_tick;

    logic       op_wr = 1'b0, op_app = 1'b0, op_strm = 1'b0;
    logic [7:0] din = 8'h00;
    logic ser_bit, ser_stb, byte_first, crc_byte, underflow, eod, busy;

    bts_txseq uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .op_wr(op_wr),
        .op_append_crc(op_app), .op_stream(op_strm), .data_in(din),
        .ser_bit(ser_bit), .ser_stb(ser_stb), .byte_first(byte_first),
        .crc_byte(crc_byte), .underflow(underflow), .eod(eod), .busy(busy)
    );

    typedef struct packed { logic b; logic f; logic ck; logic uf; logic eo; } exp_t;
    exp_t q[$];
    exp_t e;
    int total = 0, bad = 0, base = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[7] != d[i]) r = (r << 1) ^ 8'h1D;
            else              r = r << 1;
        end
        return r;
    endfunction

    function automatic void push_byte(input logic [7:0] v, input bit ck,
                                      input bit uf_last, input bit eo_last);
        for (int i = 7; i >= 0; i--)
            q.push_back('{b: v[i], f: (i == 7), ck: ck,
                          uf: (i == 0) && uf_last, eo: (i == 0) && eo_last});
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (ser_stb) begin
                check(tick_d, "R1", "strobe follows tick", 0, 1);
                if (q.size() == 0) begin
                    check(1'b0, "R1", "unexpected strobe", 1, 0);
                end else begin
                    e = q.pop_front();
                    check(ser_bit == e.b, "R3", "serial bit", ser_bit, e.b);
                    check(byte_first == e.f, "R10", "byte_first", byte_first, e.f);
                    check(crc_byte == e.ck, "R4", "crc_byte", crc_byte, e.ck);
                    check(underflow == e.uf, "R6", "underflow", underflow, e.uf);
                    check(eod == e.eo, "R12", "eod", eod, e.eo);
                end
            end else if (underflow || eod) begin
                check(1'b0, "R6", "flag without strobe", 1, 0);
            end
        end
    end

    task automatic wr_now(input logic [7:0] d, input bit app, input bit strm);
        op_wr = 1'b1; din = d; op_app = app; op_strm = strm;
        @(negedge clk);
        op_wr = 1'b0; op_app = 1'b0; din = 8'h00;
    endtask

    task automatic write_at(input int tgt, input logic [7:0] d, input bit app, input bit strm);
        while (!(bit_tick && (tk_total + 1 == base + tgt))) @(negedge clk);
        wr_now(d, app, strm);
    endtask

    task automatic run_msg(input logic [31:0] bs, input int n, input bit app,
                           input bit strm, input int last_wt, input bit dup,
                           input bit extra, input string req);
        int k;
        logic [7:0] c, v;
        bit tail_ok;
        k = (last_wt > 8) ? n - 1 : n;
        tail_ok = (k == n) && app;
        c = 8'hFF;
        for (int i = 0; i < k; i++) begin
            v = bs[8*i +: 8];
            push_byte(v, 1'b0, (i == k-1) && !tail_ok && strm,
                               (i == k-1) && !tail_ok && !strm);
            c = ref_crc(c, v);
        end
        if (tail_ok)   push_byte(~c, 1'b1, 1'b0, 1'b1);
        else if (strm) push_byte(c, 1'b1, 1'b0, 1'b1);

        @(negedge clk);
        wr_now(bs[7:0], (n == 1) && app, strm);
        base = tk_total;
        for (int i = 1; i < n; i++) begin
            if (i == n-1 && dup) write_at(8*(i-1) + 2, 8'hA5, 1'b0, strm);
            write_at(8*(i-1) + ((i == n-1) ? last_wt : 3), bs[8*i +: 8],
                     (i == n-1) && app, strm);
        end
        if (extra) write_at(8*(n-1) + 4, 8'h3C, 1'b0, strm);
        for (int w = 0; w < 2000 && (q.size() != 0 || busy); w++) @(negedge clk);
        check(q.size() == 0, req, "stream complete", q.size(), 0);
        check(!busy, "R12", "idle after message", busy, 0);
        q.delete();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs while in reset
        check({ser_bit, ser_stb, byte_first, crc_byte, underflow, eod, busy} == 7'd0,
              "R11", "reset outputs",
              {ser_bit, ser_stb, byte_first, crc_byte, underflow, eod, busy}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R2 R3 R4 R5: three bytes, normal check byte
        run_msg(32'h0056_3412, 3, 1'b1, 1'b1, 3, 1'b0, 1'b0, "R4");
        // R6: stream frame starved after two bytes
        run_msg(32'h0000_07C1, 2, 1'b0, 1'b1, 3, 1'b0, 1'b0, "R6");
        // R7: non-stream frame ends quietly
        run_msg(32'h0000_009E, 1, 1'b0, 1'b0, 3, 1'b0, 1'b0, "R7");
        // R5: write in the final-tick cycle is accepted
        run_msg(32'h0000_FF00, 2, 1'b1, 1'b1, 8, 1'b0, 1'b0, "R5");
        // R8 R6: write one tick late is ignored, underflow taken
        run_msg(32'h0000_775A, 2, 1'b1, 1'b1, 9, 1'b0, 1'b0, "R8");
        // R9: second write replaces the queued byte
        run_msg(32'h0000_4281, 2, 1'b1, 1'b1, 5, 1'b1, 1'b0, "R9");
        // R8: write during an append byte is ignored
        run_msg(32'h0000_003D, 1, 1'b1, 1'b1, 3, 1'b0, 1'b1, "R8");
        // R2: CRC reseeded for a repeat of the first message
        run_msg(32'h0056_3412, 3, 1'b1, 1'b1, 3, 1'b0, 1'b0, "R2");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R12", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule